// File: doc/BRIEF.md
# Integer ALU with HI/LO Product and Quotient Registers

This block is the execution datapath of a simple integer pipeline. A 4-bit operation code selects one of twelve functions on two operand words: three shifts, add, subtract, four bitwise functions, set-less-than, multiply and divide. A separate unsigned-mode pin changes how set-less-than, multiply and divide read their operands. For shift operations, a select pin can replace the register-supplied shift amount with a shift field taken from the instruction word (bits 10 down to 6 at the default 32-bit width).

Most operations produce a combinational result in the same cycle. Multiply and divide are different: they do not drive the result word. Instead, a pair of clocked registers, HI and LO, captures the double-width product, or the quotient and remainder, at the next rising clock edge. A zero flag shows whether the two operands subtract to zero, whatever the operation code, so branch logic can use it to decide both equal and not-equal branches. An overflow flag reports signed wrap-around on add and subtract.

The block has no handshake. The operands and control pins are plain levels, and the decode stage holds them steady for the cycle in which they are used.

Top module: `hilo_alu`

## Requirements
- R1: Code 0000 shifts operand B left (logical), code 0001 shifts B right with sign fill, and code 0010 shifts B right with zero fill. When the select pin is low, the shift amount is the low log2(WIDTH) bits of operand A.
- R2: When `shamt_sel` is high, the shift amount is `instr_shamt`, and operand A has no effect on a shift.
- R3: Code 0101 returns A+B and code 0110 returns A-B, both modulo 2^WIDTH.
- R4: `overflow` is high only for code 0101 or 0110 with `unsigned_mode` low, and only when the signed result falls outside the signed range. It is low in every other case.
- R5: Code 0111 returns A AND B, 1000 returns A OR B, 1001 returns A XOR B, and 1010 returns NOT(A OR B).
- R6: Code 1011 returns 1 when A is less than B and 0 otherwise. The comparison is two's-complement when `unsigned_mode` is low and unsigned when it is high.
- R7: Code 0011 loads the upper half of the 2*WIDTH-bit product A*B into HI and the lower half into LO at the next rising edge. The product is signed or unsigned according to `unsigned_mode`. `result` reads 0 during this code.
- R8: Code 0100 with a nonzero B loads the quotient A/B into LO and the remainder into HI at the next rising edge. In signed mode the quotient truncates toward zero and the remainder takes the sign of A. With B equal to zero, HI and LO keep their values. `result` reads 0 during this code.
- R9: HI and LO change only on a rising edge that sees code 0011 or 0100. A synchronous reset (`rst` high at a rising edge) clears both to 0.
- R10: `zero` is high exactly when A-B equals 0, for every operation code.
- R11: Codes 1100 through 1111 return a result of 0 and leave HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the HI/LO registers |
| rst | input | 1 | Synchronous reset, active high, clears HI and LO |
| op_code | input | 4 | Operation select |
| unsigned_mode | input | 1 | Selects unsigned compare, multiply and divide |
| shamt_sel | input | 1 | High: shift amount comes from `instr_shamt` |
| instr_shamt | input | log2(WIDTH) | Shift field from the instruction word |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, and the value that is shifted |
| result | output | WIDTH | Combinational result |
| zero | output | 1 | High when A-B is zero |
| overflow | output | 1 | Signed add/subtract overflow |
| hi | output | WIDTH | HI register: product upper half or remainder |
| lo | output | WIDTH | LO register: product lower half or quotient |

## Verification
The assertions assume that every control and operand pin carries a known value and stays stable from before each rising edge until after it. They also assume that reset is high from the very first edge, so HI and LO never hold unknown values while the checks are active. The bench holds `rst` high from time zero and changes inputs only on falling edges. It sweeps every 4-bit code, both settings of unsigned mode, and a fixed set of sixteen corner values for each operand, including 0, 1, the most negative value and all-ones. The select pin and the instruction shift field vary with the loop indices, so both shift-amount sources are exercised.

// File: rtl/hilo_alu_pkg.sv
package hilo_alu_pkg;
  localparam logic [3:0] OP_SLL = 4'b0000;
  localparam logic [3:0] OP_SRA = 4'b0001;
  localparam logic [3:0] OP_SRL = 4'b0010;
  localparam logic [3:0] OP_MUL = 4'b0011;
  localparam logic [3:0] OP_DIV = 4'b0100;
  localparam logic [3:0] OP_ADD = 4'b0101;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_AND = 4'b0111;
  localparam logic [3:0] OP_OR  = 4'b1000;
  localparam logic [3:0] OP_XOR = 4'b1001;
  localparam logic [3:0] OP_NOR = 4'b1010;
  localparam logic [3:0] OP_SLT = 4'b1011;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_ARITH = 2'b01,
    SH_LOGIC = 2'b10,
    SH_NONE  = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import hilo_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value,
  input  logic [SHW-1:0]   amount,
  input  shift_kind_e      kind,
  output logic [WIDTH-1:0] shifted
);
  always_comb begin
    unique case (kind)
      SH_LEFT:  shifted = value << amount;
      SH_ARITH: shifted = WIDTH'($signed(value) >>> amount);
      SH_LOGIC: shifted = value >> amount;
      default:  shifted = '0;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             unsigned_mode,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] diff,
  output logic             ovf_add,
  output logic             ovf_sub,
  output logic             less
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] diff_ext;

  assign sum      = a + b;
  assign diff_ext = {1'b0, a} - {1'b0, b};
  assign diff     = diff_ext[MSB:0];
  assign ovf_add  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign ovf_sub  = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
  // The unsigned compare uses the borrow out; the signed compare uses the sign corrected by overflow.
  assign less     = unsigned_mode ? diff_ext[WIDTH] : (diff[MSB] ^ ovf_sub);
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mul_en,
  input  logic             div_en,
  input  logic             unsigned_mode,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  localparam int DW = 2 * WIDTH;

  logic [DW-1:0]     a_wide, b_wide, product;
  logic [WIDTH:0]    a_div, b_div, b_safe, quot, rem;
  logic              divisor_zero, load;

  // Extend each operand to double width so that one multiplier serves both modes.
  assign a_wide  = unsigned_mode ? {{WIDTH{1'b0}}, a} : {{WIDTH{a[WIDTH-1]}}, a};
  assign b_wide  = unsigned_mode ? {{WIDTH{1'b0}}, b} : {{WIDTH{b[WIDTH-1]}}, b};
  assign product = a_wide * b_wide;

  // One extra bit keeps the most-negative / -1 quotient in range.
  assign a_div        = {unsigned_mode ? 1'b0 : a[WIDTH-1], a};
  assign b_div        = {unsigned_mode ? 1'b0 : b[WIDTH-1], b};
  assign divisor_zero = (b == '0);
  assign b_safe       = divisor_zero ? {{WIDTH{1'b0}}, 1'b1} : b_div;
  assign quot         = $unsigned($signed(a_div) / $signed(b_safe));
  assign rem          = $unsigned($signed(a_div) % $signed(b_safe));

  assign load = mul_en || (div_en && !divisor_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (mul_en) begin
      hi <= product[DW-1:WIDTH];
      lo <= product[WIDTH-1:0];
    end else if (div_en && !divisor_zero) begin
      hi <= rem[WIDTH-1:0];
      lo <= quot[WIDTH-1:0];
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(mul_en || div_en) |=> (hi == $past(hi)) && (lo == $past(lo)));

  p_divzero_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (div_en && (b == '0)) |=> $stable(hi) && $stable(lo));

  p_mul_zero_operand_r7: assert property (@(posedge clk) disable iff (rst)
    (mul_en && (a == '0)) |=> (hi == '0) && (lo == '0));

  p_div_self_r8: assert property (@(posedge clk) disable iff (rst)
    (div_en && unsigned_mode && (a == b) && (b != '0)) |=> (lo == WIDTH'(1)) && (hi == '0));

  p_load_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mul_en, div_en}));
endmodule

// File: rtl/hilo_alu.sv
module hilo_alu
  import hilo_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [3:0]               op_code,
  input  logic                     unsigned_mode,
  input  logic                     shamt_sel,
  input  logic [$clog2(WIDTH)-1:0] instr_shamt,
  input  logic [WIDTH-1:0]         opnd_a,
  input  logic [WIDTH-1:0]         opnd_b,
  output logic [WIDTH-1:0]         result,
  output logic                     zero,
  output logic                     overflow,
  output logic [WIDTH-1:0]         hi,
  output logic [WIDTH-1:0]         lo
);
  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0]   amount;
  shift_kind_e      kind;
  logic [WIDTH-1:0] shifted, sum, diff;
  logic             ovf_add, ovf_sub, less;
  logic             is_add, is_sub;

  assign amount = shamt_sel ? instr_shamt : opnd_a[SHW-1:0];

  always_comb begin
    unique case (op_code)
      OP_SLL:  kind = SH_LEFT;
      OP_SRA:  kind = SH_ARITH;
      OP_SRL:  kind = SH_LOGIC;
      default: kind = SH_NONE;
    endcase
  end

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .value(opnd_b), .amount(amount), .kind(kind), .shifted(shifted)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .unsigned_mode(unsigned_mode),
    .sum(sum), .diff(diff), .ovf_add(ovf_add), .ovf_sub(ovf_sub), .less(less)
  );

  alu_muldiv #(.WIDTH(WIDTH)) u_muldiv (
    .clk(clk), .rst(rst),
    .mul_en(op_code == OP_MUL), .div_en(op_code == OP_DIV),
    .unsigned_mode(unsigned_mode),
    .a(opnd_a), .b(opnd_b), .hi(hi), .lo(lo)
  );

  assign is_add   = (op_code == OP_ADD);
  assign is_sub   = (op_code == OP_SUB);
  assign overflow = !unsigned_mode && ((is_add && ovf_add) || (is_sub && ovf_sub));
  assign zero     = (diff == '0);

  always_comb begin
    unique case (op_code)
      OP_SLL, OP_SRA, OP_SRL: result = shifted;
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_NOR:  result = ~(opnd_a | opnd_b);
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, less};
      default: result = '0;
    endcase
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (unsigned_mode || !(is_add || is_sub)) |-> !overflow);

  p_add_mixed_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (is_add && (opnd_a[WIDTH-1] != opnd_b[WIDTH-1])) |-> !overflow);

  p_zero_equal_r10: assert property (@(posedge clk) disable iff (rst)
    zero == (opnd_a == opnd_b));

  p_muldiv_result_r7: assert property (@(posedge clk) disable iff (rst)
    ((op_code == OP_MUL) || (op_code == OP_DIV)) |-> (result == '0));

  p_slt_bool_r6: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_SLT) |-> ($countones(result) <= 1) && (result[WIDTH-1:1] == '0));

  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (op_code[3:2] == 2'b11) |-> (result == '0));
endmodule

// File: tb/test_hilo_alu.sv
module test_hilo_alu;
  localparam int W = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op_code = '0;
  logic          unsigned_mode = 1'b0;
  logic          shamt_sel = 1'b0;
  logic [SW-1:0] instr_shamt = '0;
  logic [W-1:0]  opnd_a = '0, opnd_b = '0;
  logic [W-1:0]  result, hi, lo;
  logic          zero, overflow;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hilo_alu #(.WIDTH(W)) i_hilo_alu (
    .clk(clk), .rst(rst), .op_code(op_code), .unsigned_mode(unsigned_mode),
    .shamt_sel(shamt_sel), .instr_shamt(instr_shamt),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .zero(zero),
    .overflow(overflow), .hi(hi), .lo(lo)
  );

  function automatic logic [W-1:0] pick(int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
      4: return 8'h05;  5: return 8'h07;  6: return 8'h0F;  7: return 8'h3F;
      8: return 8'h7F;  9: return 8'h80; 10: return 8'h81; 11: return 8'hAA;
      12: return 8'hC3; 13: return 8'hFE; 14: return 8'hFF; default: return 8'h55;
    endcase
  endfunction

  function automatic string tag(int op, bit sel);
    if (op <= 2) return sel ? "R2" : "R1";
    case (op)
      3: return "R7";  4: return "R8";  5: return "R3";  6: return "R3";
      7: return "R5";  8: return "R5";  9: return "R5"; 10: return "R5";
      11: return "R6"; default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h um=%0b actual=%h expected=%h",
               req, op_code, opnd_a, opnd_b, unsigned_mode, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_hi, exp_lo;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset hi", hi, '0);
    check("R9 reset lo", lo, '0);
    exp_hi = '0;
    exp_lo = '0;
    rst = 1'b0;

    for (int op = 0; op < 16; op++) begin
      for (int um = 0; um < 2; um++) begin
        for (int ia = 0; ia < 16; ia++) begin
          for (int ib = 0; ib < 16; ib++) begin
            int ua, ub, sa, sb, amt, r, q;
            logic [W-1:0]  e_res;
            logic          e_ovf;
            logic [15:0]   prod;
            @(negedge clk);
            op_code       = 4'(op);
            unsigned_mode = um[0];
            opnd_a        = pick(ia);
            opnd_b        = pick(ib);
            shamt_sel     = ((ia + ib) % 2) == 1;
            instr_shamt   = SW'(ib + op);
            #1;
            ua = int'(opnd_a);
            ub = int'(opnd_b);
            sa = int'($signed(opnd_a));
            sb = int'($signed(opnd_b));
            amt = shamt_sel ? int'(instr_shamt) : int'(opnd_a[SW-1:0]);
            e_ovf = 1'b0;
            case (op)
              0: e_res = 8'(ub << amt);
              1: e_res = 8'(sb >>> amt);
              2: e_res = 8'(ub >> amt);
              5: begin
                e_res = 8'(ua + ub);
                e_ovf = (um == 0) && ((sa + sb > 127) || (sa + sb < -128));
              end
              6: begin
                e_res = 8'(ua - ub);
                e_ovf = (um == 0) && ((sa - sb > 127) || (sa - sb < -128));
              end
              7: e_res = opnd_a & opnd_b;
              8: e_res = opnd_a | opnd_b;
              9: e_res = opnd_a ^ opnd_b;
              10: e_res = ~(opnd_a | opnd_b);
              11: e_res = (um == 1) ? 8'(ua < ub) : 8'(sa < sb);
              default: e_res = '0;
            endcase
            check(tag(op, shamt_sel), result, e_res);
            check("R10 zero", {7'b0, zero}, {7'b0, ua == ub});
            check("R4 overflow", {7'b0, overflow}, {7'b0, e_ovf});

            @(posedge clk);
            #1;
            if (op == 3) begin
              prod = (um == 1) ? 16'(ua * ub) : 16'(sa * sb);
              exp_hi = prod[15:8];
              exp_lo = prod[7:0];
            end else if (op == 4 && ub != 0) begin
              q = (um == 1) ? ua / ub : sa / sb;
              r = (um == 1) ? ua % ub : sa % sb;
              exp_hi = 8'(r);
              exp_lo = 8'(q);
            end
            check(op == 3 ? "R7 hi" : (op == 4 ? "R8 hi" : "R9 hi"), hi, exp_hi);
            check(op == 3 ? "R7 lo" : (op == 4 ? "R8 lo" : "R9 lo"), lo, exp_lo);
          end
        end
      end
    end

    @(negedge clk);
    op_code = 4'b0011;
    unsigned_mode = 1'b1;
    opnd_a = 8'hFF;
    opnd_b = 8'hFF;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R9 reset clears hi", hi, '0);
    check("R9 reset clears lo", lo, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule